// File: doc/BRIEF.md
# Overcurrent Hiccup Protection Controller

This clocked controller sits in the digital core of a synchronous buck converter, between the analog comparators and the gate drivers. It passes the PWM request through to two gate-permit outputs, one for each switch. A peak current-limit flag cuts the high-side conduction at once and hands the interval to the low-side switch. The low-side switch keeps conducting until the low-side limit comparator reports that the inductor current has fallen back.

When limiting goes on and the feedback stays below 70% of its reference, the controller starts counting ticks of a separate blanking timebase. If the condition holds for the whole blanking count, the controller declares a hiccup fault. It turns both switches off and asks for the soft-start reference and the compensation node to be pulled low. It then waits a fixed number of switching ticks and opens a restart window of a fixed length, during which overload qualification is suspended. At the close of the window it either resumes normal switching or goes back into hiccup.

Dropping enable, or raising the undervoltage flag, asynchronously returns the block to an idle state with both switches off. Every start, including the first one after reset, begins with the restart window.

Top module: `buck_hiccup_ctrl`

## Requirements
- R1: Enable low, undervoltage high or reset low forces `hs_permit` and `ls_permit` to 0 and `ss_discharge` and `comp_clamp` to 1 without waiting for a clock edge. It also clears every timer and the blanking count, so a partial overload count does not survive a restart.
- R2: When enable returns (and reset is released, undervoltage low), the first clock edge starts a restart window. `ss_discharge` is 0 from that edge on.
- R3: In normal operation `hs_permit` equals `pwm_on` and `ls_permit` equals its inverse. The two permits are never 1 together.
- R4: While `hs_limit` is 1, `hs_permit` is 0 and `ls_permit` is 1 in the same cycle, whatever the value of `pwm_on`.
- R5: After a cycle with `hs_limit` at 1, the low-side switch stays on and the high side stays off until a clock edge samples `ls_limit` at 0. High-side permission returns in the cycle after that edge.
- R6: Hiccup is declared when `fb_low` is 1 and limiting is active (`hs_limit` at 1, or the R5 hold in force) on BLANK_TICKS consecutive `blank_tick` edges (default 36). Any edge on which the condition is absent restarts the count from zero.
- R7: During hiccup, both permits are 0 and `ss_discharge` and `comp_clamp` are 1.
- R8: The hiccup off interval lasts OFF_CYCLES `sw_tick` edges (default 896), then a restart window begins.
- R9: A restart window lasts RETRY_CYCLES `sw_tick` edges (default 112). Overload qualification (R6) is suspended for the whole window, while R4 and R5 still apply.
- R10: At the end of a restart window, hiccup is re-entered if `fb_low` is 1 and `hs_limit` was 1 at any edge in the window. Otherwise normal operation resumes and `ss_discharge` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Converter enable; low forces idle asynchronously |
| uv_fault | input | 1 | Supply undervoltage flag; high forces idle asynchronously |
| sw_tick | input | 1 | One-cycle strobe per switching period |
| blank_tick | input | 1 | Strobe of the blanking timebase |
| pwm_on | input | 1 | High-side request from the PWM comparator |
| hs_limit | input | 1 | High-side peak current-limit flag |
| ls_limit | input | 1 | Low-side current-limit flag |
| fb_low | input | 1 | Feedback below 70% of the reference |
| hs_permit | output | 1 | High-side gate permit |
| ls_permit | output | 1 | Low-side gate permit |
| ss_discharge | output | 1 | Request to pull the soft-start reference low |
| comp_clamp | output | 1 | Request to pull the compensation node low |

## Verification
The hardest situation to reach from the ports is the repeated hiccup cycle. It needs a fault that qualifies, survives a complete off interval, and is then judged again at the end of a restart window whose internal state is not visible.

The stimulus holds the peak-limit and low-feedback flags from the moment enable rises. It then measures the lengths of the successive low and high runs of `ss_discharge` (112, 896, 112). Clearing the flags during a later off interval and watching `ss_discharge` stay low shows that normal operation has resumed.

A blanking count is also interrupted by one missing cycle and, separately, by an undervoltage pulse. In both cases the bench confirms that the count restarts from zero.

// File: rtl/buck_hiccup_ctrl.sv
module buck_hiccup_ctrl #(
  parameter int OFF_CYCLES   = 896,
  parameter int RETRY_CYCLES = 112,
  parameter int BLANK_TICKS  = 36
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic uv_fault,
  input  logic sw_tick,
  input  logic blank_tick,
  input  logic pwm_on,
  input  logic hs_limit,
  input  logic ls_limit,
  input  logic fb_low,
  output logic hs_permit,
  output logic ls_permit,
  output logic ss_discharge,
  output logic comp_clamp
);

  localparam int MAXC = (OFF_CYCLES > RETRY_CYCLES) ? OFF_CYCLES : RETRY_CYCLES;
  localparam int CW   = (MAXC > 1) ? $clog2(MAXC) : 1;
  localparam int BW   = (BLANK_TICKS > 1) ? $clog2(BLANK_TICKS) : 1;

  typedef enum logic [1:0] {S_IDLE, S_RETRY, S_RUN, S_OFF} state_t;

  state_t        state;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bcnt;
  logic          ls_hold;
  logic          seen;

  wire kill_n   = rst_n & enable & ~uv_fault;
  wire switching = (state == S_RETRY) || (state == S_RUN);
  wire active   = kill_n & switching;
  wire limiting = hs_limit | ls_hold;
  wire qual     = fb_low & limiting;
  wire hs_gate  = pwm_on & ~limiting;

  assign hs_permit    = active & hs_gate;
  assign ls_permit    = active & ~hs_gate;
  assign ss_discharge = ~kill_n | (state == S_IDLE) | (state == S_OFF);
  assign comp_clamp   = ss_discharge;

  always_ff @(posedge clk or negedge kill_n) begin
    if (!kill_n) begin
      state   <= S_IDLE;
      cnt     <= '0;
      bcnt    <= '0;
      ls_hold <= 1'b0;
      seen    <= 1'b0;
    end else begin
      ls_hold <= switching & (hs_limit | (ls_hold & ls_limit));
      case (state)
        S_IDLE: begin
          state <= S_RETRY;
          cnt   <= '0;
          seen  <= 1'b0;
        end
        S_RETRY: begin
          if (hs_limit) seen <= 1'b1;
          if (sw_tick) begin
            if (cnt == CW'(RETRY_CYCLES - 1)) begin
              state <= (fb_low && (seen || hs_limit)) ? S_OFF : S_RUN;
              cnt   <= '0;
              seen  <= 1'b0;
              bcnt  <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        S_RUN: begin
          if (!qual) begin
            bcnt <= '0;
          end else if (blank_tick) begin
            if (bcnt == BW'(BLANK_TICKS - 1)) begin
              state <= S_OFF;
              bcnt  <= '0;
              cnt   <= '0;
            end else begin
              bcnt <= bcnt + 1'b1;
            end
          end
        end
        S_OFF: begin
          if (sw_tick) begin
            if (cnt == CW'(OFF_CYCLES - 1)) begin
              state <= S_RETRY;
              cnt   <= '0;
              seen  <= 1'b0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/buck_hiccup_ctrl_chk.sv
module buck_hiccup_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic uv_fault,
  input logic hs_limit,
  input logic ls_limit,
  input logic hs_permit,
  input logic ls_permit,
  input logic ss_discharge,
  input logic comp_clamp
);

  assert_kill_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable || uv_fault) |-> (!hs_permit && !ls_permit && ss_discharge));

  assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_permit && ls_permit));

  assert_peak_cut_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hs_limit |-> !hs_permit);

  assert_ls_hold_R5: assert property (@(posedge clk) disable iff (!rst_n || !enable || uv_fault)
    (hs_limit && ls_limit) |=> !hs_permit);

  assert_hiccup_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ss_discharge |-> (!hs_permit && !ls_permit && comp_clamp));

  assert_off_persist_R8: assert property (@(posedge clk) disable iff (!rst_n || !enable || uv_fault)
    $rose(ss_discharge) |=> ss_discharge);

endmodule

bind buck_hiccup_ctrl buck_hiccup_ctrl_chk chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .uv_fault(uv_fault),
  .hs_limit(hs_limit), .ls_limit(ls_limit), .hs_permit(hs_permit),
  .ls_permit(ls_permit), .ss_discharge(ss_discharge), .comp_clamp(comp_clamp)
);

// File: tb/buck_hiccup_ctrl_test.sv
module buck_hiccup_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n, enable, uv_fault, sw_tick, blank_tick;
  logic pwm_on, hs_limit, ls_limit, fb_low;
  logic hs_permit, ls_permit, ss_discharge, comp_clamp;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  buck_hiccup_ctrl uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .uv_fault(uv_fault),
    .sw_tick(sw_tick), .blank_tick(blank_tick), .pwm_on(pwm_on),
    .hs_limit(hs_limit), .ls_limit(ls_limit), .fb_low(fb_low),
    .hs_permit(hs_permit), .ls_permit(ls_permit),
    .ss_discharge(ss_discharge), .comp_clamp(comp_clamp)
  );

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic run_len(input logic level, input int limit, output int n);
    n = 0;
    while (ss_discharge == level && n < limit) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic set_fault(input logic v);
    hs_limit = v;
    fb_low   = v;
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check("R1 reset hs", hs_permit, 0);
    check("R1 reset ls", ls_permit, 0);
    check("R1 reset discharge", ss_discharge, 1);
    check("R1 reset clamp", comp_clamp, 1);
  endtask

  task automatic t_hiccup_cycle;
    int n;
    set_fault(1'b1);
    rst_n  = 1'b1;
    enable = 1'b1;
    @(negedge clk);
    run_len(1'b0, 2000, n);
    check("R2 R9 startup window length", n, 112);
    run_len(1'b1, 2000, n);
    check("R8 off interval", n, 896);
    run_len(1'b0, 2000, n);
    check("R10 reenter after retry", n, 112);
    set_fault(1'b0);
    run_len(1'b1, 2000, n);
    check("R8 second off interval", n, 896);
    run_len(1'b0, 400, n);
    check("R10 resume normal", n, 400);
  endtask

  task automatic t_pwm;
    pwm_on = 1'b1; #1;
    check("R3 hs on", hs_permit, 1);
    check("R3 ls off", ls_permit, 0);
    @(negedge clk);
    pwm_on = 1'b0; #1;
    check("R3 hs off", hs_permit, 0);
    check("R3 ls on", ls_permit, 1);
    @(negedge clk);
  endtask

  task automatic t_peak;
    pwm_on = 1'b1; hs_limit = 1'b1; ls_limit = 1'b1; #1;
    check("R4 hs cut", hs_permit, 0);
    check("R4 ls on", ls_permit, 1);
    @(negedge clk);
    hs_limit = 1'b0; #1;
    check("R5 hold hs", hs_permit, 0);
    check("R5 hold ls", ls_permit, 1);
    @(negedge clk);
    ls_limit = 1'b0; #1;
    check("R5 hs before edge", hs_permit, 0);
    @(negedge clk); #1;
    check("R5 hs released", hs_permit, 1);
    check("R5 ls released", ls_permit, 0);
    @(negedge clk);
  endtask

  task automatic t_blank;
    pwm_on = 1'b1;
    set_fault(1'b1);
    repeat (35) @(negedge clk);
    check("R6 no hiccup at 35", ss_discharge, 0);
    fb_low = 1'b0;
    @(negedge clk);
    fb_low = 1'b1;
    repeat (35) @(negedge clk);
    check("R6 count restarted", ss_discharge, 0);
    @(negedge clk);
    check("R6 hiccup at 36", ss_discharge, 1);
    check("R7 clamp", comp_clamp, 1);
    check("R7 hs off", hs_permit, 0);
    check("R7 ls off", ls_permit, 0);
    set_fault(1'b0);
    pwm_on = 1'b0;
  endtask

  task automatic t_kill;
    int n;
    repeat (10) @(negedge clk);
    enable = 1'b0; #1;
    check("R1 enable low discharge", ss_discharge, 1);
    check("R1 enable low ls", ls_permit, 0);
    @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
    run_len(1'b0, 200, n);
    check("R2 restart after enable", n, 200);
    pwm_on = 1'b0;
    set_fault(1'b1);
    repeat (30) @(negedge clk);
    uv_fault = 1'b1; #1;
    check("R1 uv ls off", ls_permit, 0);
    check("R1 uv discharge", ss_discharge, 1);
    set_fault(1'b0);
    @(negedge clk);
    uv_fault = 1'b0;
    repeat (150) @(negedge clk);
    set_fault(1'b1);
    repeat (10) @(negedge clk);
    check("R1 blank count cleared", ss_discharge, 0);
    set_fault(1'b0);
    pwm_on = 1'b1;
    @(negedge clk);
    uv_fault = 1'b1; #1;
    check("R1 uv hs off", hs_permit, 0);
    @(negedge clk);
    uv_fault = 1'b0;
    pwm_on = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; enable = 1'b0; uv_fault = 1'b0;
    sw_tick = 1'b1; blank_tick = 1'b1;
    pwm_on = 1'b0; hs_limit = 1'b0; ls_limit = 1'b0; fb_low = 1'b0;
    t_reset();
    t_hiccup_cycle();
    t_pwm();
    t_peak();
    t_blank();
    t_kill();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule